// File: doc/BRIEF.md
# Per-Chip-Select Refresh Scheduler With Masking

This block paces auto-refresh for a memory array built from up to four chip selects. A free-running interval counter produces one refresh opportunity every configured number of cycles. The cadence is the same whether the surrounding controller is busy, idle or in a low-power state. At each opportunity the block raises a refresh request together with a vector naming the chip selects to refresh. The request stays up until the command side accepts it with a one-cycle handshake.

While the low-power indicator is high, a per-chip-select suppress vector can remove chosen chip selects from the refresh vector. Outside low power the suppress vector has no effect. When every candidate chip select is removed, no request is raised, but the counter keeps running. The block does not check that a suppressed chip select is refreshed often enough; software has to ensure that. With a single chip select the suppress vector is ignored.

A request that has not been accepted when the next opportunity arrives is not duplicated. The new chip selects are folded into the pending request instead.

Top module: `refsched_top`

## Requirements
- R1: With `intervalCfg` = P (P >= 1) held from reset, a new request appears after rising edges P, 2P, 3P, ... counted from the first edge with `rstN` high. The spacing does not depend on `lowPower` or `maskEn`.
- R2: An `intervalCfg` of 0 behaves as 1. If `intervalCfg` is lowered to a value at or below the count already reached, an opportunity occurs in the next cycle and counting restarts from zero.
- R3: With `lowPower` low when an opportunity is taken, `refCs` equals `csPresent` whatever `maskEn` holds.
- R4: With `lowPower` high when an opportunity is taken, `refCs` equals `csPresent & ~maskEn`, where bit i of every vector belongs to chip select i.
- R5: When the filtered vector is zero, no request is raised. The interval counter keeps running, so the next opportunity after unmasking keeps the original cadence.
- R6: A raised request keeps `refReq` high and `refCs` unchanged until `refAck` is high at a rising edge. It then drops after that edge unless a new opportunity coincides.
- R7: An opportunity that arrives while a request is pending and not accepted raises no second request. `refCs` becomes the OR of the held vector and the new filtered vector.
- R8: An opportunity on the same edge as an acceptance starts a new request at once with only the new filtered vector, and `refReq` stays high.
- R9: During and just after reset, `refReq` is 0, `refCs` is 0 and the counter is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intervalCfg | input | CNT_W | Refresh interval in cycles |
| csPresent | input | NUM_CS | Chip selects fitted in the array |
| lowPower | input | 1 | High while a low-power state is active |
| maskEn | input | NUM_CS | Per-chip-select refresh suppress bits, used only in low power |
| refAck | input | 1 | Command side accepts the pending request at this edge |
| refReq | output | 1 | Refresh request pending |
| refCs | output | NUM_CS | Chip selects to refresh; zero while no request is pending |

## Verification
The counter-range assertion assumes that `intervalCfg` changes only as a step, so the count can exceed the limit for at most the one cycle after the change. The stimulus changes it once, downward, and otherwise holds it from reset. The handshake assertions treat `refAck` as meaningful only while `refReq` is high. The bench leaves the acknowledge high during idle stretches and uses the held-low case only around a pending request. All inputs change one time unit after a rising edge, so every opportunity samples settled values of `lowPower`, `maskEn` and `csPresent`.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  // Control-to-datapath strobes, at most one active per cycle
  typedef struct packed {
    logic capture;  // load a fresh chip-select vector
    logic merge;    // fold new vector into held one
    logic clear;    // drop the held vector
  } refStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } refState_t;
endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] intervalCfg,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntNext;

  // Widened compare: a limit of 0 or 1 ticks every cycle, and a limit
  // lowered below the running count ticks at once.
  assign cntNext = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign tick    = cntNext >= {1'b0, intervalCfg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cntNext[CNT_W-1:0];
  end

  // R2: with a steady nonzero limit the count stays below it
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(intervalCfg) && intervalCfg != '0) |-> (cnt < intervalCfg));

  // R9: counter restarts from zero after reset
  assert_reset_cnt_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cnt <= {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       vecNonZero,
  input  logic       refAck,
  output refStrobe_t strobe,
  output logic       reqActive
);
  refState_t state, stateNext;
  logic      fire;

  assign fire      = tick && vecNonZero;
  assign reqActive = (state == ST_PEND);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (fire) begin
          strobe.capture = 1'b1;
          stateNext      = ST_PEND;
        end
      end
      ST_PEND: begin
        if (refAck) begin
          if (fire) begin
            strobe.capture = 1'b1;   // back-to-back request (R8)
          end else begin
            strobe.clear = 1'b1;
            stateNext    = ST_IDLE;
          end
        end else if (fire) begin
          strobe.merge = 1'b1;       // collapse into pending (R7)
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capture, strobe.merge, strobe.clear}));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqActive && !refAck) |=> reqActive);

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqActive && refAck && !tick) |=> !reqActive);

  assert_chain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqActive && refAck && fire) |=> reqActive);
endmodule

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CS-1:0] csPresent,
  input  logic              lowPower,
  input  logic [NUM_CS-1:0] maskEn,
  input  refStrobe_t        strobe,
  output logic              vecNonZero,
  output logic [NUM_CS-1:0] csHeld
);
  logic [NUM_CS-1:0] effMask;
  logic [NUM_CS-1:0] candVec;

  generate
    if (NUM_CS > 1) begin : g_mask
      assign effMask = maskEn & {NUM_CS{lowPower}};

      // R4: a captured vector never names a chip select suppressed in low power
      assert_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture |=> ((csHeld & $past(maskEn & {NUM_CS{lowPower}})) == '0));
    end else begin : g_single
      // One chip select: suppression has no meaning
      logic unusedMask;
      assign unusedMask = ^maskEn;
      assign effMask    = '0;
    end
  endgenerate

  assign candVec    = csPresent & ~effMask;
  assign vecNonZero = |candVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              csHeld <= '0;
    else if (strobe.clear)  csHeld <= '0;
    else if (strobe.capture) csHeld <= candVec;
    else if (strobe.merge)  csHeld <= csHeld | candVec;
  end

  // R3: outside low power a fresh vector covers every fitted chip select
  assert_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !lowPower) |=> (csHeld == $past(csPresent)));
endmodule

// File: rtl/refsched_top.sv
module refsched_top
  import refsched_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  intervalCfg,
  input  logic [NUM_CS-1:0] csPresent,
  input  logic              lowPower,
  input  logic [NUM_CS-1:0] maskEn,
  input  logic              refAck,
  output logic              refReq,
  output logic [NUM_CS-1:0] refCs
);
  logic       tick;
  logic       vecNonZero;
  refStrobe_t strobe;

  refsched_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rstN(rstN), .intervalCfg(intervalCfg), .tick(tick)
  );

  refsched_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .vecNonZero(vecNonZero),
    .refAck(refAck), .strobe(strobe), .reqActive(refReq)
  );

  refsched_dp #(.NUM_CS(NUM_CS)) u_dp (
    .clk(clk), .rstN(rstN), .csPresent(csPresent), .lowPower(lowPower),
    .maskEn(maskEn), .strobe(strobe), .vecNonZero(vecNonZero), .csHeld(refCs)
  );

  assert_nonzero_vec_R5: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> (refCs != '0));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !refReq |-> (refCs == '0));

  assert_no_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refAck) |=> ((refCs & $past(refCs)) == $past(refCs)));
endmodule

// File: tb/refsched_top_tb.sv
module refsched_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int CW = 16;

  typedef struct {
    int             edgeNo;
    logic [NCS-1:0] vec;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [CW-1:0]  intervalCfg = '0;
  logic [NCS-1:0] csPresent = '0;
  logic           lowPower = 1'b0;
  logic [NCS-1:0] maskEn = '0;
  logic           refAck = 1'b1;
  logic           refReq;
  logic [NCS-1:0] refCs;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  logic ackAtEdge = 1'b0;
  logic prevReq = 1'b0;
  bit done = 0;
  expItem_t expQ[$];

  refsched_top #(.NUM_CS(NCS), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .intervalCfg(intervalCfg), .csPresent(csPresent),
    .lowPower(lowPower), .maskEn(maskEn), .refAck(refAck),
    .refReq(refReq), .refCs(refCs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
    ackAtEdge <= refAck;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edgeCnt);
    end
  endtask

  // Monitor: detect each newly started request and compare against the queue
  always @(negedge clk) begin
    if (!rstN) begin
      prevReq = 1'b0;
    end else begin
      if (refReq && (!prevReq || ackAtEdge)) begin
        if (expQ.size() == 0) begin
          check(0, "R1 unexpected request", edgeCnt, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.edgeNo == edgeCnt, "R1 request edge", edgeCnt, it.edgeNo);
          check(it.vec == refCs, "R3/R4 request vector", refCs, it.vec);
        end
      end
      prevReq = refReq;
    end
  end

  function automatic logic [NCS-1:0] expVec(logic [NCS-1:0] cs, logic lp, logic [NCS-1:0] m);
    return lp ? (cs & ~m) : cs;
  endfunction

  task automatic push(input int e, input logic [NCS-1:0] v);
    expItem_t it;
    if (v != '0) begin
      it.edgeNo = e;
      it.vec = v;
      expQ.push_back(it);
    end
  endtask

  task automatic waitEdge(input int e);
    while (edgeCnt < e) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic startRun(input int cfg, input logic [NCS-1:0] cs, input logic lp,
                          input logic [NCS-1:0] m, input logic ack);
    @(posedge clk); #1;
    rstN = 1'b0;
    intervalCfg = CW'(cfg);
    csPresent = cs;
    lowPower = lp;
    maskEn = m;
    refAck = ack;
    expQ.delete();
    repeat (2) @(posedge clk);
    #1;
    check(refReq == 1'b0, "R9 reset refReq", refReq, 0);
    check(refCs == '0, "R9 reset refCs", refCs, 0);
    rstN = 1'b1;
  endtask

  task automatic finishRun(input int stopE, input string tag);
    waitEdge(stopE);
    @(negedge clk); #1;
    check(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  initial begin
    // R1, R3: normal power, suppress bits ignored
    startRun(5, 4'b1111, 1'b0, 4'b1010, 1'b1);
    push(5, 4'b1111); push(10, 4'b1111); push(15, 4'b1111);
    finishRun(17, "R1 missing request");

    // R1, R4: low power, suppress bits applied, same cadence
    startRun(5, 4'b1111, 1'b1, 4'b1010, 1'b1);
    push(5, 4'b0101); push(10, 4'b0101); push(15, 4'b0101);
    finishRun(17, "R4 missing request");

    // R3: partially fitted array
    startRun(4, 4'b0110, 1'b0, 4'b1111, 1'b1);
    push(4, 4'b0110); push(8, 4'b0110);
    finishRun(10, "R3 missing request");

    // R5: all suppressed, counter keeps running
    startRun(3, 4'b1111, 1'b1, 4'b1111, 1'b1);
    push(12, 4'b1111);
    waitEdge(10);
    check(refReq == 1'b0, "R5 no request when all masked", refReq, 0);
    maskEn = 4'b0000;
    finishRun(14, "R5 cadence after unmask");

    // R3, R4: power state toggles between opportunities
    startRun(6, 4'b1111, 1'b0, 4'b0100, 1'b1);
    push(6, 4'b1111);
    push(12, expVec(4'b1111, 1'b1, 4'b0100));
    push(18, 4'b1111);
    waitEdge(8);  lowPower = 1'b1;
    waitEdge(14); lowPower = 1'b0;
    finishRun(20, "R3/R4 toggle run");

    // R2, R8: limit of zero ticks every cycle, acceptance chains requests
    startRun(0, 4'b1001, 1'b0, 4'b0000, 1'b1);
    for (int e = 1; e <= 8; e++) push(e, 4'b1001);
    waitEdge(8);
    check(refReq == 1'b1, "R2 continuous request at zero limit", refReq, 1);
    finishRun(8, "R2 zero limit");

    // R2: limit lowered below the running count
    startRun(8, 4'b1111, 1'b0, 4'b0000, 1'b1);
    push(6, 4'b1111); push(9, 4'b1111); push(12, 4'b1111);
    waitEdge(5);
    intervalCfg = CW'(3);
    finishRun(14, "R2 lowered limit");

    // R6, R7: held request, merge on unaccepted opportunity
    startRun(4, 4'b1111, 1'b1, 4'b0001, 1'b0);
    push(4, 4'b1110);
    push(12, 4'b0111);
    waitEdge(6);
    maskEn = 4'b1000;
    waitEdge(7);
    check(refReq == 1'b1, "R6 request held", refReq, 1);
    check(refCs == 4'b1110, "R6 vector held", refCs, 4'b1110);
    waitEdge(8);
    check(refReq == 1'b1, "R7 single pending request", refReq, 1);
    check(refCs == 4'b1111, "R7 merged vector", refCs, 4'b1111);
    waitEdge(9);
    refAck = 1'b1;
    waitEdge(10);
    check(refReq == 1'b0, "R6 drop after accept", refReq, 0);
    check(refCs == 4'b0000, "R6 vector cleared", refCs, 0);
    finishRun(14, "R7 run");

    // R8: acceptance coincides with an opportunity
    startRun(4, 4'b1111, 1'b1, 4'b0001, 1'b0);
    push(4, 4'b1110);
    push(8, 4'b0111);
    waitEdge(5);
    maskEn = 4'b1000;
    waitEdge(7);
    refAck = 1'b1;
    waitEdge(8);
    check(refReq == 1'b1, "R8 request stays high", refReq, 1);
    check(refCs == 4'b0111, "R8 fresh vector only", refCs, 4'b0111);
    waitEdge(9);
    check(refReq == 1'b0, "R8 drop after second accept", refReq, 0);
    finishRun(10, "R8 run");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", edgeCnt, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule